// File: doc/BRIEF.md
# Banked DRAM Command Scheduler with Per-Bank Refresh

This block connects a single-request user port to the command and address pins of an eight-bank, low-latency DRAM. It issues at most one command per clock: a no-operation (deselect), a mode-register load, a read, a write or a single-bank auto-refresh. User requests carry a kind, a bank and a location address. They are accepted on a valid/ready handshake, and each accepted request appears on the command pins on the following cycle.

An interval timer sets how many refreshes are owed. In spread mode, one refresh falls due each interval. In posted mode, eight refreshes fall due together once every eight intervals and go out back to back. A small debt counter keeps track of the refreshes that are owed. A refresh whose target bank is still busy is delayed and made up later, not lost. Each bank has a busy counter that runs for a fixed number of cycles after every read, write or refresh to that bank. Commands to a busy bank wait. A mode-register load waits until every bank is idle. Each write carries two data-mask bits, one for each half of the burst.

Top module: `dram_cmd_sched`

## Requirements
- R1: While reset is asserted, `cmd_o` is NOP (0) and `cmd_bank_o`, `cmd_addr_o` and `cmd_dm_o` are zero.
- R2: A request accepted with `req_valid_i` and `req_ready_o` both high at a clock edge appears on the command pins after that edge. The command encoding is NOP=0, MRS=1, READ=2, WRITE=3, AREF=4. The request kind encoding is 00 read, 01 write, 1x mode-register load. A read or write drives its bank and its full 20-bit address.
- R3: A WRITE drives `cmd_dm_o` with the request's mask. Bit 0 high suppresses the first half of the burst and bit 1 high suppresses the second half. Every other command drives `cmd_dm_o` to zero.
- R4: In a cycle with no accepted request and no refresh issued, `cmd_o` is NOP with bank, address and mask all zero.
- R5: A READ, WRITE or AREF to a bank appears no sooner than BUSY_CYCLES cycles after the previous such command to the same bank. A command to a different, idle bank may follow on the next cycle.
- R6: An MRS is issued only once every bank has gone BUSY_CYCLES cycles without a command. It drives bank zero and the request's low 18 address bits, with bits 19:18 forced to zero.
- R7: In spread mode (`ref_posted_i` low), one AREF falls due every REF_INTERVAL cycles, counted from the release of reset. With no traffic, consecutive AREFs are exactly REF_INTERVAL cycles apart. The refresh bank rotates 0,1,…,7,0 across all AREFs.
- R8: In posted mode (`ref_posted_i` high), eight AREFs fall due every 8×REF_INTERVAL cycles. With no traffic they issue on eight consecutive cycles, one per bank.
- R9: An AREF drives `cmd_addr_o` to zero.
- R10: While any refresh is owed, `req_ready_o` is low. Refreshes delayed by a busy bank are kept and issued later, so the number of AREFs issued catches up with the number that have fallen due.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_posted_i | input | 1 | Refresh mode: 0 spread single, 1 posted burst of eight |
| req_valid_i | input | 1 | User request valid |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_kind_i | input | 2 | 00 read, 01 write, 1x mode-register load |
| req_bank_i | input | 3 | Target bank |
| req_addr_i | input | 20 | Location address; low 18 bits are the mode value for a mode-register load |
| req_dm_i | input | 2 | Burst-half mask for a write |
| cmd_o | output | 3 | Command: 0 NOP, 1 MRS, 2 READ, 3 WRITE, 4 AREF |
| cmd_bank_o | output | 3 | Command bank |
| cmd_addr_o | output | 20 | Command address |
| cmd_dm_o | output | 2 | Burst-half data mask |

## Verification
The properties assume that `ref_posted_i` changes only while reset is asserted. The spread-mode rotation and interval reasoning relies on this. They also assume that request fields are stable from the moment valid is raised until the handshake completes. The bench drives every request at the falling edge and holds it until ready is seen high. It changes the refresh mode only during a reset. It draws bank, kind, mask and address from a linear feedback register, so the load is mixed and reaches both the busy-bank stalls and the refresh hold-off.

// File: rtl/dram_sched_pkg.sv
`timescale 1ns/1ps
package dram_sched_pkg;
  localparam int NUM_BANKS = 8;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int ADDR_W    = 20;
  localparam int MODE_W    = 18;
  localparam int DM_W      = 2;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_MRS   = 3'd1,
    CMD_READ  = 3'd2,
    CMD_WRITE = 3'd3,
    CMD_AREF  = 3'd4
  } cmd_e;
endpackage

// File: rtl/refresh_timer.sv
`timescale 1ns/1ps
module refresh_timer #(
  parameter int INTERVAL = 195,
  parameter int BURST    = 8,
  parameter int DEBT_W   = 5,
  parameter int BANK_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              posted_i,
  input  logic              grant_i,
  output logic              due_o,
  output logic [BANK_W-1:0] bank_o
);
  localparam int PERIOD_MAX = INTERVAL * BURST;
  localparam int CNT_W      = $clog2(PERIOD_MAX + 1);
  localparam int DEBT_MAX   = (1 << DEBT_W) - 1;

  logic [CNT_W-1:0]  cnt_q, limit;
  logic              tick;
  logic [DEBT_W-1:0] debt_q;
  logic [DEBT_W:0]   debt_sum, debt_add;
  logic [BANK_W-1:0] bank_q;

  assign limit    = posted_i ? CNT_W'(PERIOD_MAX - 1) : CNT_W'(INTERVAL - 1);
  assign tick     = (cnt_q >= limit);
  assign debt_add = tick ? (posted_i ? (DEBT_W+1)'(BURST) : (DEBT_W+1)'(1)) : '0;
  // grant only when debt is nonzero, so no underflow
  assign debt_sum = {1'b0, debt_q} + debt_add - {{DEBT_W{1'b0}}, grant_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      debt_q <= '0;
      bank_q <= '0;
    end else begin
      cnt_q  <= tick ? '0 : cnt_q + 1'b1;
      debt_q <= (debt_sum > (DEBT_W+1)'(DEBT_MAX)) ? DEBT_W'(DEBT_MAX) : debt_sum[DEBT_W-1:0];
      if (grant_i) bank_q <= bank_q + 1'b1;
    end
  end

  assign due_o  = (debt_q != '0);
  assign bank_o = bank_q;
endmodule

// File: rtl/bank_busy.sv
`timescale 1ns/1ps
module bank_busy #(
  parameter int NUM_BANKS   = 8,
  parameter int BANK_W      = 3,
  parameter int BUSY_CYCLES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 issue_i,
  input  logic [BANK_W-1:0]    issue_bank_i,
  output logic [NUM_BANKS-1:0] busy_o
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cnt_q <= '0;
      else if (issue_i && issue_bank_i == BANK_W'(b))
        cnt_q <= CW'(BUSY_CYCLES - 1);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
    assign busy_o[b] = (cnt_q != '0);
  end
endmodule

// File: rtl/dram_cmd_sched.sv
`timescale 1ns/1ps
module dram_cmd_sched
  import dram_sched_pkg::*;
#(
  parameter int REF_INTERVAL = 195,
  parameter int BUSY_CYCLES  = 4,
  parameter int DEBT_W       = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_posted_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_kind_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DM_W-1:0]   req_dm_i,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DM_W-1:0]   cmd_dm_o
);
  logic [NUM_BANKS-1:0] busy;
  logic                 ref_due, ref_go, all_idle, is_mrs, accept, issue;
  logic [BANK_W-1:0]    ref_bank, issue_bank;

  cmd_e              cmd_d, cmd_q;
  logic [BANK_W-1:0] bank_d, bank_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [DM_W-1:0]   dm_d, dm_q;

  refresh_timer #(
    .INTERVAL (REF_INTERVAL),
    .BURST    (NUM_BANKS),
    .DEBT_W   (DEBT_W),
    .BANK_W   (BANK_W)
  ) u_ref (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .posted_i (ref_posted_i),
    .grant_i  (ref_go),
    .due_o    (ref_due),
    .bank_o   (ref_bank)
  );

  bank_busy #(
    .NUM_BANKS   (NUM_BANKS),
    .BANK_W      (BANK_W),
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_busy (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .issue_i      (issue),
    .issue_bank_i (issue_bank),
    .busy_o       (busy)
  );

  assign all_idle    = ~|busy;
  assign is_mrs      = req_kind_i[1];
  assign ref_go      = ref_due && !busy[ref_bank];
  // refresh owed blocks all user traffic
  assign req_ready_o = !ref_due && (is_mrs ? all_idle : !busy[req_bank_i]);
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    cmd_d      = CMD_NOP;
    bank_d     = '0;
    addr_d     = '0;
    dm_d       = '0;
    issue      = 1'b0;
    issue_bank = ref_bank;
    if (ref_go) begin
      cmd_d  = CMD_AREF;
      bank_d = ref_bank;
      issue  = 1'b1;
    end else if (accept) begin
      if (is_mrs) begin
        cmd_d  = CMD_MRS;
        addr_d = ADDR_W'(req_addr_i[MODE_W-1:0]);
      end else begin
        cmd_d      = req_kind_i[0] ? CMD_WRITE : CMD_READ;
        bank_d     = req_bank_i;
        addr_d     = req_addr_i;
        dm_d       = req_kind_i[0] ? req_dm_i : '0;
        issue      = 1'b1;
        issue_bank = req_bank_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_NOP;
      bank_q <= '0;
      addr_q <= '0;
      dm_q   <= '0;
    end else begin
      cmd_q  <= cmd_d;
      bank_q <= bank_d;
      addr_q <= addr_d;
      dm_q   <= dm_d;
    end
  end

  assign cmd_o      = cmd_q;
  assign cmd_bank_o = bank_q;
  assign cmd_addr_o = addr_q;
  assign cmd_dm_o   = dm_q;
endmodule

// File: rtl/dram_cmd_sched_chk.sv
`timescale 1ns/1ps
module dram_cmd_sched_chk
  import dram_sched_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [2:0]        cmd_o,
  input logic [BANK_W-1:0] cmd_bank_o,
  input logic [ADDR_W-1:0] cmd_addr_o,
  input logic [DM_W-1:0]   cmd_dm_o
);
  localparam int SW = $clog2(BUSY_CYCLES + 1);

  logic [SW-1:0]     since_q [NUM_BANKS];
  logic [BANK_W-1:0] ref_ptr_q;
  logic              bank_cmd, all_quiet;

  assign bank_cmd = (cmd_o == CMD_READ) || (cmd_o == CMD_WRITE) || (cmd_o == CMD_AREF);

  always_comb begin
    all_quiet = 1'b1;
    for (int b = 0; b < NUM_BANKS; b++)
      if (since_q[b] < SW'(BUSY_CYCLES)) all_quiet = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NUM_BANKS; b++) since_q[b] <= SW'(BUSY_CYCLES);
      ref_ptr_q <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bank_cmd && cmd_bank_o == BANK_W'(b))
          since_q[b] <= SW'(1);
        else if (since_q[b] < SW'(BUSY_CYCLES))
          since_q[b] <= since_q[b] + 1'b1;
      end
      if (cmd_o == CMD_AREF) ref_ptr_q <= ref_ptr_q + 1'b1;
    end
  end

  p_accept_issue_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=>
      (cmd_o == CMD_READ || cmd_o == CMD_WRITE || cmd_o == CMD_MRS));

  p_dm_write_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != CMD_WRITE) |-> (cmd_dm_o == '0));

  p_bank_spacing_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_cmd |-> (since_q[cmd_bank_o] >= SW'(BUSY_CYCLES)));

  p_mrs_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_MRS) |-> (all_quiet && cmd_bank_o == '0 && cmd_addr_o[ADDR_W-1:MODE_W] == '0));

  p_ref_rotation_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_AREF) |-> (cmd_bank_o == ref_ptr_q));

  p_aref_addr_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_AREF) |-> (cmd_addr_o == '0));
endmodule

bind dram_cmd_sched dram_cmd_sched_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .cmd_o       (cmd_o),
  .cmd_bank_o  (cmd_bank_o),
  .cmd_addr_o  (cmd_addr_o),
  .cmd_dm_o    (cmd_dm_o)
);

// File: tb/dram_cmd_sched_tb_top.sv
`timescale 1ns/1ps
module dram_cmd_sched_tb_top;
  localparam int REF_I = 64;
  localparam int BUSY  = 4;
  localparam int POST  = 8 * REF_I;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        posted = 1'b0;
  logic        valid = 1'b0;
  logic        ready;
  logic [1:0]  kind = '0;
  logic [2:0]  bank = '0;
  logic [19:0] addr = '0;
  logic [1:0]  dm = '0;
  logic [2:0]  cmd;
  logic [2:0]  cmd_bank;
  logic [19:0] cmd_addr;
  logic [1:0]  cmd_dm;

  always #2.5 clk = ~clk;

  dram_cmd_sched #(.REF_INTERVAL(REF_I), .BUSY_CYCLES(BUSY), .DEBT_W(5)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ref_posted_i(posted),
    .req_valid_i(valid), .req_ready_o(ready), .req_kind_i(kind),
    .req_bank_i(bank), .req_addr_i(addr), .req_dm_i(dm),
    .cmd_o(cmd), .cmd_bank_o(cmd_bank), .cmd_addr_o(cmd_addr), .cmd_dm_o(cmd_dm)
  );

  typedef struct packed {
    logic [2:0]  c;
    logic [2:0]  b;
    logic [19:0] a;
    logic [1:0]  m;
  } item_t;

  item_t exp_q[$];
  int    ucyc[$];
  int    n_chk = 0, n_bad = 0;
  int    cyc, aref_cnt, last_aref, aref_gap, run, max_run, exp_ref;
  bit    done = 0;
  logic [15:0] lf = 16'hACE1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (cmd == 3'd4) begin
        check(cmd_bank == 3'(exp_ref), "R7", "aref bank", cmd_bank, exp_ref);
        check(cmd_addr == '0, "R9", "aref addr", cmd_addr, 0);
        exp_ref  = (exp_ref + 1) % 8;
        aref_cnt++;
        if (last_aref >= 0) aref_gap = cyc - last_aref;
        run = (last_aref == cyc - 1) ? run + 1 : 1;
        if (run > max_run) max_run = run;
        last_aref = cyc;
      end else if (cmd == 3'd0) begin
        check(cmd_bank == 0 && cmd_addr == 0 && cmd_dm == 0, "R4", "nop fields",
              {cmd_bank, cmd_addr, cmd_dm}, 0);
      end else if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected command", cmd, 0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        ucyc.push_back(cyc);
        check(cmd == e.c, "R2", "cmd", cmd, e.c);
        check(cmd_bank == e.b, "R2", "bank", cmd_bank, e.b);
        check(cmd_addr == e.a, (e.c == 3'd1) ? "R6" : "R2", "addr", cmd_addr, e.a);
        check(cmd_dm == e.m, "R3", "mask", cmd_dm, e.m);
      end
    end
  end

  task automatic send(input logic [1:0] k, input logic [2:0] b, input logic [19:0] a, input logic [1:0] m);
    item_t e;
    @(negedge clk);
    valid = 1'b1; kind = k; bank = b; addr = a; dm = m;
    #1;
    while (!ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    e.c = k[1] ? 3'd1 : (k[0] ? 3'd3 : 3'd2);
    e.b = k[1] ? 3'd0 : b;
    e.a = k[1] ? {2'b00, a[17:0]} : a;
    e.m = (k == 2'b01) ? m : 2'b00;
    exp_q.push_back(e);
  endtask

  task automatic quiet();
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic wait_mid(input int period);
    do @(negedge clk); while ((cyc % period) != period / 2);
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; valid = 1'b0; posted = mode;
    repeat (3) @(negedge clk);
    check(cmd == 0 && cmd_bank == 0 && cmd_addr == 0 && cmd_dm == 0, "R1", "reset outputs",
          {cmd, cmd_bank, cmd_addr, cmd_dm}, 0);
    exp_q.delete(); ucyc.delete();
    aref_cnt = 0; last_aref = -1000; aref_gap = 0; run = 0; max_run = 0; exp_ref = 0;
    rst_n = 1'b1;
  endtask

  task automatic traffic(input int n);
    for (int i = 0; i < n; i++) begin
      logic [1:0] k;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      k  = (lf[3:0] == 4'd0) ? 2'b10 : {1'b0, lf[11]};
      send(k, lf[6:4], {lf, lf[3:0]}, lf[9:8]);
    end
    quiet();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      check(1'b0, "R10", "watchdog expired", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // spread mode
    do_reset(1'b0);
    repeat (20) @(negedge clk);
    check(aref_cnt == 0 && exp_q.size() == 0, "R4", "idle before first interval", aref_cnt, 0);

    send(2'b00, 3'd3, 20'hABCDE, 2'b11);   // read: mask forced to zero
    send(2'b00, 3'd3, 20'h12345, 2'b00);
    send(2'b00, 3'd4, 20'hFFFFF, 2'b00);
    send(2'b01, 3'd1, 20'h00F0F, 2'b01);
    send(2'b10, 3'd6, 20'hFFFFF, 2'b00);   // MRS: bank and top bits dropped
    send(2'b01, 3'd2, 20'h55555, 2'b10);
    send(2'b01, 3'd5, 20'hAAAAA, 2'b11);
    quiet();
    repeat (10) @(negedge clk);
    check(ucyc.size() == 7, "R2", "issued user commands", ucyc.size(), 7);
    if (ucyc.size() == 7) begin
      check(ucyc[1] - ucyc[0] == BUSY, "R5", "same-bank gap", ucyc[1] - ucyc[0], BUSY);
      check(ucyc[2] - ucyc[1] == 1, "R5", "other-bank gap", ucyc[2] - ucyc[1], 1);
      check(ucyc[4] - ucyc[3] == BUSY, "R6", "mrs wait for idle", ucyc[4] - ucyc[3], BUSY);
    end

    // idle spread refresh
    while (cyc < 4 * REF_I) @(negedge clk);
    wait_mid(REF_I);
    check(aref_gap == REF_I, "R7", "spread aref gap", aref_gap, REF_I);
    check(last_aref % REF_I == 1, "R7", "spread aref phase", last_aref % REF_I, 1);
    check(aref_cnt == cyc / REF_I, "R10", "spread aref count idle", aref_cnt, cyc / REF_I);

    // loaded spread refresh
    traffic(1500);
    repeat (2 * REF_I) @(negedge clk);
    wait_mid(REF_I);
    check(aref_cnt == cyc / REF_I, "R10", "spread aref count loaded", aref_cnt, cyc / REF_I);
    check(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);

    // posted mode
    do_reset(1'b1);
    repeat (10) @(negedge clk);
    check(cmd == 0, "R1", "nop after reset", cmd, 0);
    traffic(600);
    repeat (POST) @(negedge clk);
    wait_mid(POST);
    check(aref_cnt == 8 * (cyc / POST), "R10", "posted aref count loaded", aref_cnt, 8 * (cyc / POST));
    max_run = 0;
    repeat (POST) @(negedge clk);
    check(max_run == 8, "R8", "posted burst length", max_run, 8);
    check((last_aref - 7) % POST == 1, "R8", "posted burst phase", (last_aref - 7) % POST, 1);
    check(aref_cnt == 8 * (cyc / POST), "R8", "posted aref count idle", aref_cnt, 8 * (cyc / POST));
    check(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule